// File: doc/BRIEF.md
# Key-Locked System Control Register Block

This block is a bank of 32-bit configuration words for clocking, reset and pin setup. It sits in a 4 KB address window and is reached through a small request bus. A request carries a valid bit, a read/write select, a byte address and write data. Read responses come back one cycle after the request. The block never applies back-pressure: `req_ready` is held high, so every request is taken in the cycle it is presented. The response channel has no ready input and cannot be stalled, so the requester must be able to take a response in the cycle after each read.

Software protection comes from a write lock. The block leaves reset locked. While locked, ordinary configuration writes are dropped and reported on a one-cycle error pin. The block unlocks only when a 16-bit unlock key is written to its own word. Locking again needs a different key written to another word.

Each decoded word has an access class: read-write, read-only or write-only. A write that breaks its class, a read that breaks its class, and any access to an undecoded word all raise a one-cycle invalid-access pulse. An accepted write to the reset-control word with bit 0 set raises a one-cycle soft-reset request.

Top module: `sysctl_keyreg`

## Requirements
- R1: After reset, `locked` is 1 and the status word at byte 0x00C reads 1. The outputs `rsp_valid`, `err_invalid`, `err_locked` and `soft_rst_req` are 0. Reads return these defaults: 0x0001A008 at 0x100, 0x104 and 0x108; 0x00014000 at 0x110, 0x114 and 0x118; 0x0000003F at 0x10C; 0x00000040 at 0x254; 0x00000001 at 0x25C; the `ID_WORD` parameter at 0x530; 0 at 0x000 and 0x200.
- R2: `req_ready` is always 1. A read taken in cycle n gives `rsp_valid`=1 with the stored word in cycle n+1. No other cycle shows `rsp_valid`. Address bits [1:0] are ignored.
- R3: A write to 0x004 whose data bits [15:0] equal 0x767B sets `locked`. Bits [31:16] are ignored. Any other value leaves `locked` unchanged and flags no error.
- R4: A write to 0x008 whose data bits [15:0] equal 0xDF0D clears `locked`. Bits [31:16] are ignored. Any other value leaves `locked` unchanged and flags no error.
- R5: While `locked` is 1, a write to any read-write word other than 0x000, or to the write-only word 0x60C, is discarded. It raises `err_locked` for exactly the next cycle.
- R6: The word at 0x000 stores only bit 0 of the write data. It accepts writes even while locked, with no error.
- R7: A write to a read-only word (0x00C, 0x10C, 0x25C, 0x530) or to an undecoded offset changes nothing and raises `err_invalid` in the next cycle.
- R8: A read of a write-only word (0x004, 0x008, 0x60C) or of an undecoded offset returns 0 with `rsp_valid` and raises `err_invalid` in the same response cycle.
- R9: An unlocked write to 0x200 with data bit 0 set stores the word and pulses `soft_rst_req` for exactly the next cycle. Bit 0 stays set until software clears it. A locked write to 0x200 raises no request.
- R10: There are `NUM_PIN` pin-setup words starting at 0x700. They are read-write and reset to 0x00001601, except words 2 to 8, which reset to 0x00000601.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted; held at 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 32 | Read response data |
| locked | output | 1 | Write lock status |
| err_invalid | output | 1 | Class or decode violation, one cycle |
| err_locked | output | 1 | Write dropped by the lock, one cycle |
| soft_rst_req | output | 1 | Soft-reset request pulse |

## Verification
The assertions assume that `req_valid` and `req_write` are known on every clock edge after reset. They also assume at most one request per cycle, which the bus enforces, so a read response and a write error can never come from the same request. The stimulus drives every request on a falling edge and holds it for one full cycle. It then drops `req_valid` for at least one cycle, so each error pulse and soft-reset pulse is tied to exactly one request. No address is driven with undefined bits.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int ADDR_BITS = 12;
  localparam int WORD_BITS = ADDR_BITS - 2;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RW   = 2'd1,
    ACC_RO   = 2'd2,
    ACC_WO   = 2'd3
  } acc_e;

  localparam logic [15:0] KEY_LOCK   = 16'h767B;
  localparam logic [15:0] KEY_UNLOCK = 16'hDF0D;

  // word indices (byte offset / 4)
  localparam logic [WORD_BITS-1:0] W_CTRL   = 10'h000;
  localparam logic [WORD_BITS-1:0] W_LOCK   = 10'h001;
  localparam logic [WORD_BITS-1:0] W_UNLOCK = 10'h002;
  localparam logic [WORD_BITS-1:0] W_LSTAT  = 10'h003;
  localparam logic [WORD_BITS-1:0] W_PLLC   = 10'h040;
  localparam logic [WORD_BITS-1:0] W_PSTAT  = 10'h043;
  localparam logic [WORD_BITS-1:0] W_PLLF   = 10'h044;
  localparam logic [WORD_BITS-1:0] W_RSTC   = 10'h080;
  localparam logic [WORD_BITS-1:0] W_RSNR   = 10'h095;
  localparam logic [WORD_BITS-1:0] W_BOOT   = 10'h097;
  localparam logic [WORD_BITS-1:0] W_IDENT  = 10'h14C;
  localparam logic [WORD_BITS-1:0] W_CAL    = 10'h183;
  localparam logic [WORD_BITS-1:0] W_PIN0   = 10'h1C0;

  // stored slots: fixed words first, then pin words
  localparam int FIXED_SLOTS = 12;
  localparam int SLOT_CTRL   = 0;
  localparam int SLOT_RSTC   = 8;

  function automatic logic [WORD_BITS-1:0] slot_word(input int s);
    case (s)
      0:  return W_CTRL;
      1:  return W_PLLC;
      2:  return W_PLLC + 10'd1;
      3:  return W_PLLC + 10'd2;
      4:  return W_PSTAT;
      5:  return W_PLLF;
      6:  return W_PLLF + 10'd1;
      7:  return W_PLLF + 10'd2;
      8:  return W_RSTC;
      9:  return W_RSNR;
      10: return W_BOOT;
      11: return W_IDENT;
      default: return WORD_BITS'(int'(W_PIN0) + s - FIXED_SLOTS);
    endcase
  endfunction

  function automatic acc_e slot_class(input int s);
    case (s)
      4, 10, 11: return ACC_RO;
      default:   return ACC_RW;
    endcase
  endfunction

  function automatic logic [31:0] slot_default(input int s, input logic [31:0] ident);
    int pin;
    pin = s - FIXED_SLOTS;
    case (s)
      0:       return 32'h0;
      1, 2, 3: return 32'h0001_A008;
      4:       return 32'h0000_003F;
      5, 6, 7: return 32'h0001_4000;
      8:       return 32'h0;
      9:       return 32'h0000_0040;
      10:      return 32'h0000_0001;
      11:      return ident;
      default: return (pin >= 2 && pin <= 8) ? 32'h0000_0601 : 32'h0000_1601;
    endcase
  endfunction

  function automatic logic [31:0] slot_mask(input int s);
    return (s == SLOT_CTRL) ? 32'h0000_0001 : 32'hFFFF_FFFF;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int NUM_SLOTS = FIXED_SLOTS + 54,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic [WORD_BITS-1:0] word,
  output logic                 slot_hit,
  output logic [SW-1:0]        slot,
  output acc_e                 cls,
  output logic                 is_lock,
  output logic                 is_unlock,
  output logic                 is_lstat,
  output logic                 is_cal
);

  always_comb begin
    slot_hit = 1'b0;
    slot     = '0;
    cls      = ACC_NONE;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (word == slot_word(s)) begin
        slot_hit = 1'b1;
        slot     = SW'(s);
        cls      = slot_class(s);
      end
    end
    is_lock   = (word == W_LOCK);
    is_unlock = (word == W_UNLOCK);
    is_lstat  = (word == W_LSTAT);
    is_cal    = (word == W_CAL);
    if (is_lock || is_unlock || is_cal) cls = ACC_WO;
    if (is_lstat) cls = ACC_RO;
  end

endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock
  import sysctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lock,
  input  logic        wr_unlock,
  input  logic [15:0] key,
  output logic        locked_q
);

  logic set_hit, clr_hit;
  assign set_hit = wr_lock   && (key == KEY_LOCK);
  assign clr_hit = wr_unlock && (key == KEY_UNLOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked_q <= 1'b1;
    else if (set_hit) locked_q <= 1'b1;
    else if (clr_hit) locked_q <= 1'b0;
  end

  AST_LOCK_KEY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && key == 16'h767B) |=> locked_q); // R3
  AST_UNLOCK_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unlock && key == 16'hDF0D) |=> !locked_q); // R4
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lock || wr_unlock) |=> $stable(locked_q)); // R4

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int          NUM_SLOTS = FIXED_SLOTS + 54,
  parameter logic [31:0] ID_WORD   = 32'h0372_7093,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wslot,
  input  logic [31:0]   wdata,
  input  logic [SW-1:0] rslot,
  output logic [31:0]   rdata
);

  logic [31:0] store [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [31:0] RST_VAL = slot_default(g, ID_WORD);
    localparam logic [31:0] MASK    = slot_mask(g);
    if (slot_class(g) == ACC_RW) begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        store[g] <= RST_VAL;
        else if (we && wslot == SW'(g))    store[g] <= wdata & MASK;
      end
    end else begin : g_ro
      assign store[g] = RST_VAL;
    end
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (rslot == SW'(s)) rdata = store[s];
  end

endmodule

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg
  import sysctl_pkg::*;
#(
  parameter int          NUM_PIN = 54,
  parameter logic [31:0] ID_WORD = 32'h0372_7093
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_BITS-1:0] req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_data,
  output logic                 locked,
  output logic                 err_invalid,
  output logic                 err_locked,
  output logic                 soft_rst_req
);

  localparam int NUM_SLOTS = FIXED_SLOTS + NUM_PIN;
  localparam int SW        = $clog2(NUM_SLOTS);

  logic          fire, wr, rd;
  logic          slot_hit, is_lock, is_unlock, is_lstat, is_cal;
  logic [SW-1:0] slot;
  acc_e          cls;
  logic          locked_q;
  logic [31:0]   rdata;
  logic          is_ctrl, needs_unlock, lock_err, bad_wr, bad_rd, store_en, srst;

  assign req_ready = 1'b1;
  assign fire      = req_valid && req_ready;
  assign wr        = fire && req_write;
  assign rd        = fire && !req_write;

  sysctl_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .word      (req_addr[ADDR_BITS-1:2]),
    .slot_hit  (slot_hit),
    .slot      (slot),
    .cls       (cls),
    .is_lock   (is_lock),
    .is_unlock (is_unlock),
    .is_lstat  (is_lstat),
    .is_cal    (is_cal)
  );

  sysctl_lock u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lock   (wr && is_lock),
    .wr_unlock (wr && is_unlock),
    .key       (req_wdata[15:0]),
    .locked_q  (locked_q)
  );

  assign is_ctrl      = slot_hit && (slot == SW'(SLOT_CTRL));
  assign needs_unlock = wr && ((cls == ACC_RW && !is_ctrl) || is_cal);
  assign lock_err     = needs_unlock && locked_q;
  assign bad_wr       = wr && (cls == ACC_NONE || cls == ACC_RO);
  assign bad_rd       = rd && (cls == ACC_NONE || cls == ACC_WO);
  assign store_en     = wr && slot_hit && cls == ACC_RW && (is_ctrl || !locked_q);
  assign srst         = needs_unlock && !locked_q && slot_hit &&
                        (slot == SW'(SLOT_RSTC)) && req_wdata[0];

  sysctl_regfile #(.NUM_SLOTS(NUM_SLOTS), .ID_WORD(ID_WORD)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_en),
    .wslot (slot),
    .wdata (req_wdata),
    .rslot (slot),
    .rdata (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      err_invalid  <= 1'b0;
      err_locked   <= 1'b0;
      soft_rst_req <= 1'b0;
    end else begin
      rsp_valid    <= rd;
      if (rd) begin
        if (bad_rd)        rsp_data <= '0;
        else if (is_lstat) rsp_data <= {31'b0, locked_q};
        else               rsp_data <= rdata;
      end
      err_invalid  <= bad_wr || bad_rd;
      err_locked   <= lock_err;
      soft_rst_req <= srst;
    end
  end

  assign locked = locked_q;

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R2
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R2
  AST_LOCK_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_locked |-> $past(locked)); // R5
  AST_SRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |-> $past(req_valid && req_write && !locked && req_wdata[0])); // R9
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && err_invalid) |-> (rsp_data == 32'h0)); // R8
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_invalid && err_locked)); // R7

endmodule

// File: tb/sysctl_keyreg_test.sv
module sysctl_keyreg_test;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] IDW        = 32'h0372_7093;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, locked, err_invalid, err_locked, soft_rst_req;
  logic [31:0] rsp_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] exp_data[$];
  logic        exp_err[$];
  string       exp_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_keyreg #(.NUM_PIN(54), .ID_WORD(IDW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .locked(locked),
    .err_invalid(err_invalid), .err_locked(err_locked), .soft_rst_req(soft_rst_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read responses
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_data.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual=unexpected response expected=none");
      end else begin
        automatic logic [31:0] d = exp_data.pop_front();
        automatic logic        e = exp_err.pop_front();
        automatic string       t = exp_tag.pop_front();
        check(t, rsp_data, d);
        check(t, {31'b0, err_invalid}, {31'b0, e});
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] d, input logic e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_data.push_back(d); exp_err.push_back(e); exp_tag.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic e_inv, input logic e_lck, input logic e_sr, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(t, {29'b0, err_invalid, err_locked, soft_rst_req}, {29'b0, e_inv, e_lck, e_sr});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 lock", {31'b0, locked}, 32'd1);
    check("R1 outs", {28'b0, rsp_valid, err_invalid, err_locked, soft_rst_req}, 32'd0);
    check("R2 ready", {31'b0, req_ready}, 32'd1);
    rd(12'h00C, 32'd1, 1'b0, "R1 lstat");
    rd(12'h100, 32'h0001_A008, 1'b0, "R1 pllc0");
    rd(12'h108, 32'h0001_A008, 1'b0, "R1 pllc2");
    rd(12'h10C, 32'h0000_003F, 1'b0, "R1 pstat");
    rd(12'h118, 32'h0001_4000, 1'b0, "R1 pllf2");
    rd(12'h254, 32'h0000_0040, 1'b0, "R1 reason");
    rd(12'h25F, 32'h0000_0001, 1'b0, "R2 boot lowbits");
    rd(12'h530, IDW, 1'b0, "R1 ident");
    rd(12'h200, 32'h0, 1'b0, "R1 rstc");
    rd(12'h700, 32'h0000_1601, 1'b0, "R10 pin0");
    rd(12'h708, 32'h0000_0601, 1'b0, "R10 pin2");
    rd(12'h720, 32'h0000_0601, 1'b0, "R10 pin8");
    rd(12'h724, 32'h0000_1601, 1'b0, "R10 pin9");
    rd(12'h7D4, 32'h0000_1601, 1'b0, "R10 pin53");
    // locked writes dropped
    wr(12'h100, 32'h1234_5678, 1'b0, 1'b1, 1'b0, "R5 locked write");
    rd(12'h100, 32'h0001_A008, 1'b0, "R5 unchanged");
    wr(12'h60C, 32'h1, 1'b0, 1'b1, 1'b0, "R5 locked wo");
    wr(12'h200, 32'h1, 1'b0, 1'b1, 1'b0, "R9 locked no pulse");
    // control word
    wr(12'h000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R6 ctrl locked");
    rd(12'h000, 32'h1, 1'b0, "R6 ctrl bit0");
    // keys
    wr(12'h008, 32'h0000_DF0E, 1'b0, 1'b0, 1'b0, "R4 wrong key");
    check("R4 still locked", {31'b0, locked}, 32'd1);
    wr(12'h008, 32'hABCD_DF0D, 1'b0, 1'b0, 1'b0, "R4 unlock");
    check("R4 unlocked", {31'b0, locked}, 32'd0);
    rd(12'h00C, 32'd0, 1'b0, "R4 lstat");
    wr(12'h100, 32'h1234_5678, 1'b0, 1'b0, 1'b0, "R2 write");
    rd(12'h100, 32'h1234_5678, 1'b0, "R2 readback");
    wr(12'h71C, 32'h0000_00A5, 1'b0, 1'b0, 1'b0, "R10 pin write");
    rd(12'h71C, 32'h0000_00A5, 1'b0, "R10 pin readback");
    // class violations
    wr(12'h10C, 32'h0, 1'b1, 1'b0, 1'b0, "R7 ro write");
    rd(12'h10C, 32'h0000_003F, 1'b0, "R7 ro unchanged");
    wr(12'h00C, 32'h1, 1'b1, 1'b0, 1'b0, "R7 lstat write");
    check("R7 lock kept", {31'b0, locked}, 32'd0);
    wr(12'h900, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R7 undecoded write");
    rd(12'h900, 32'h0, 1'b1, "R8 undecoded read");
    rd(12'h004, 32'h0, 1'b1, "R8 lock read");
    rd(12'h60C, 32'h0, 1'b1, "R8 wo read");
    wr(12'h60C, 32'h1, 1'b0, 1'b0, 1'b0, "R5 wo unlocked");
    // soft reset
    wr(12'h200, 32'h0000_0003, 1'b0, 1'b0, 1'b1, "R9 pulse");
    @(negedge clk);
    check("R9 pulse width", {31'b0, soft_rst_req}, 32'd0);
    rd(12'h200, 32'h0000_0003, 1'b0, "R9 stored");
    wr(12'h200, 32'h0000_0002, 1'b0, 1'b0, 1'b0, "R9 bit0 clear");
    // relock
    wr(12'h004, 32'h0000_767C, 1'b0, 1'b0, 1'b0, "R3 wrong key");
    check("R3 still unlocked", {31'b0, locked}, 32'd0);
    wr(12'h004, 32'hFFFF_767B, 1'b0, 1'b0, 1'b0, "R3 lock");
    check("R3 locked", {31'b0, locked}, 32'd1);
    wr(12'h254, 32'h0, 1'b0, 1'b1, 1'b0, "R5 relocked");
    rd(12'h254, 32'h0000_0040, 1'b0, "R5 reason kept");
    repeat (3) @(negedge clk);
    check("R2 all responses", exp_data.size(), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule